// File: doc/BRIEF.md
# Hardened Machine-Mode Trap Entry Controller

This block owns the trap-vector base register of a small RISC-V style core and works out where the program counter must go when an exception or interrupt is taken. Software reads and writes the register through a simple CSR port. The pipeline presents trap requests with a cause code and an interrupt flag. In the same cycle the block answers with a redirect strobe and a target address, and it tracks the machine-mode privilege level.

The block is hardened against fault storms. The vector register comes out of reset pointing at a parameterised halt routine. A sticky flag records whether software has ever written the vector, and a trap taken before that write can be configured to stop the core. A nested-fault tracker notices a trap that arrives while an earlier one is still unresolved. Depending on a parameter, it halts at the first nested fault, or it allows one double-fault redirect and halts on the triple fault. Once the halt output is raised it stays high until reset, and no further redirect is issued.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, the CSR read value equals HALT_ADDR (mode bits 00). The init flag, halt and fault level all read 0, and the machine-mode output reads 1.
- R2: A CSR write updates the register at the next clock edge. A read returns all bits written, including both mode bits. A trap in the same cycle as a write still uses the old value.
- R3: With mode bits [1:0] = 0, every trap redirects to the register value with bits [1:0] cleared, and the redirect strobe is raised in the same cycle as the request.
- R4: With mode bits = 1, an interrupt (irq flag 1) redirects to base + 4 × cause, and an exception (irq flag 0) redirects to base.
- R5: Mode bits 2 and 3 behave as direct mode: the target is the base for both interrupts and exceptions.
- R6: A taken trap sets the machine-mode output from the next cycle. The return-from-trap input clears it.
- R7: The init flag is set by the first CSR write and never clears before reset. With HALT_UNINIT = 1, a trap while the flag is clear gives no redirect, and halt rises on the next cycle. With HALT_UNINIT = 0, such a trap redirects to HALT_ADDR.
- R8: The fault level is encoded as 0 idle, 1 in trap, 2 double fault, 3 triple fault. A taken trap moves the level from 0 to 1. The handler-retire input or the return-from-trap input returns it to 0.
- R9: With ESCALATE = 0, a trap arriving while the level is nonzero is not redirected. Halt rises on the next cycle, and the level becomes 2.
- R10: With ESCALATE = 1, a trap at level 1 is redirected and moves the level to 2. A trap at level 2 is not redirected, and it sets the level to 3 and raises halt.
- R11: Halt stays high until reset, and while it is high the redirect strobe never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Write strobe for the vector register |
| csr_wdata_i | input | XLEN | Write data (base and mode bits) |
| csr_rdata_o | output | XLEN | Current vector register value |
| trap_req_i | input | 1 | Trap request from the pipeline |
| trap_irq_i | input | 1 | 1 = asynchronous interrupt, 0 = exception |
| trap_cause_i | input | CAUSE_W | Cause code |
| handler_ret_i | input | 1 | Handler retired its first instruction |
| mret_i | input | 1 | Return-from-trap executed |
| redirect_valid_o | output | 1 | Redirect the PC this cycle |
| redirect_pc_o | output | XLEN | Trap target address |
| priv_m_o | output | 1 | Core is in machine mode |
| tvec_init_o | output | 1 | Software has written the vector |
| fault_level_o | output | 2 | Nesting level (0..3) |
| halt_o | output | 1 | Core stopped, sticky |

## Verification
The assertions watch several properties on every cycle:
- Halt stays sticky, and it excludes any redirect.
- Every redirect is backed by a request and lands on an aligned target.
- Machine mode follows every taken trap.
- The init flag never falls.
- An uninitialised or nested trap leads to halt, as configured.

The exact target arithmetic needs the directed scenarios to show it. These cover vectored interrupt offsets, reserved-mode fallback, the old value used by a trap that coincides with a write, and the double-to-triple escalation path.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE   = 2'd0,
    LVL_TRAP   = 2'd1,
    LVL_DOUBLE = 2'd2,
    LVL_TRIPLE = 2'd3
  } fault_lvl_e;

  typedef enum logic [1:0] {
    TV_DIRECT   = 2'd0,
    TV_VECTORED = 2'd1,
    TV_RSVD2    = 2'd2,
    TV_RSVD3    = 2'd3
  } tvec_mode_e;
endpackage

// File: rtl/tvec_reg.sv
module tvec_reg #(
  parameter int unsigned XLEN      = 32,
  parameter logic [XLEN-1:0] RST_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] tvec_o,
  output logic            init_o
);
  logic [XLEN-1:0] tvec_q;
  logic            init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tvec_q <= RST_VAL;
      init_q <= 1'b0;
    end else if (we_i) begin
      tvec_q <= wdata_i;
      init_q <= 1'b1;
    end
  end

  assign tvec_o = tvec_q;
  assign init_o = init_q;
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_entry_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic [XLEN-1:0]    tvec_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    pc_o
);
  localparam int unsigned PAD_W = XLEN - CAUSE_W - 2;

  tvec_mode_e      mode;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign mode = tvec_mode_e'(tvec_i[1:0]);
  assign base = {tvec_i[XLEN-1:2], 2'b00};

  generate
    if (PAD_W > 0) begin : g_pad
      assign offset = {{PAD_W{1'b0}}, cause_i, 2'b00};
    end else begin : g_trunc
      assign offset = {cause_i[XLEN-3:0], 2'b00};
    end
  endgenerate

  // reserved modes fall back to direct
  always_comb begin
    pc_o = base;
    if (mode == TV_VECTORED && irq_i) pc_o = base + offset;
  end
endmodule

// File: rtl/fault_ctrl.sv
module fault_ctrl
  import trap_entry_pkg::*;
#(
  parameter bit ESCALATE    = 1'b0,
  parameter bit HALT_UNINIT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trap_req_i,
  input  logic       init_i,
  input  logic       retire_i,
  input  logic       mret_i,
  output logic       take_o,
  output logic       halt_o,
  output logic       priv_m_o,
  output logic [1:0] level_o
);
  fault_lvl_e level_q, level_d;
  logic       halt_q, priv_q;
  logic       nested, uninit_stop, nest_stop, halt_now, take;

  assign nested      = (level_q != LVL_IDLE);
  assign uninit_stop = HALT_UNINIT && !init_i;
  assign nest_stop   = nested && (!ESCALATE || level_q != LVL_TRAP);
  assign halt_now    = trap_req_i && !halt_q && (uninit_stop || nest_stop);
  assign take        = trap_req_i && !halt_q && !halt_now;

  always_comb begin
    level_d = level_q;
    if (halt_q) begin
      level_d = level_q;
    end else if (halt_now) begin
      if (nested) level_d = (level_q == LVL_DOUBLE) ? LVL_TRIPLE : LVL_DOUBLE;
    end else if (take) begin
      level_d = nested ? LVL_DOUBLE : LVL_TRAP;
    end else if (retire_i || mret_i) begin
      level_d = LVL_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= LVL_IDLE;
      halt_q  <= 1'b0;
      priv_q  <= 1'b1;
    end else begin
      level_q <= level_d;
      if (halt_now) halt_q <= 1'b1;
      if (take) priv_q <= 1'b1;
      else if (mret_i && !halt_q) priv_q <= 1'b0;
    end
  end

  assign take_o   = take;
  assign halt_o   = halt_q;
  assign priv_m_o = priv_q;
  assign level_o  = level_q;
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned CAUSE_W     = 5,
  parameter logic [XLEN-1:0] HALT_ADDR = 32'h0000_0100,
  parameter bit          ESCALATE    = 1'b0,
  parameter bit          HALT_UNINIT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  input  logic               trap_req_i,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic               handler_ret_i,
  input  logic               mret_i,
  output logic               redirect_valid_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic               priv_m_o,
  output logic               tvec_init_o,
  output logic [1:0]         fault_level_o,
  output logic               halt_o
);
  logic [XLEN-1:0] tvec;
  logic            init;
  logic            take;

  tvec_reg #(.XLEN(XLEN), .RST_VAL(HALT_ADDR)) u_tvec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (csr_we_i),
    .wdata_i(csr_wdata_i),
    .tvec_o (tvec),
    .init_o (init)
  );

  trap_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_target (
    .tvec_i (tvec),
    .irq_i  (trap_irq_i),
    .cause_i(trap_cause_i),
    .pc_o   (redirect_pc_o)
  );

  fault_ctrl #(.ESCALATE(ESCALATE), .HALT_UNINIT(HALT_UNINIT)) u_fault (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trap_req_i(trap_req_i),
    .init_i    (init),
    .retire_i  (handler_ret_i),
    .mret_i    (mret_i),
    .take_o    (take),
    .halt_o    (halt_o),
    .priv_m_o  (priv_m_o),
    .level_o   (fault_level_o)
  );

  assign csr_rdata_o      = tvec;
  assign tvec_init_o      = init;
  assign redirect_valid_o = take;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned CAUSE_W     = 5,
  parameter bit          ESCALATE    = 1'b0,
  parameter bit          HALT_UNINIT = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            csr_we_i,
  input logic            trap_req_i,
  input logic            redirect_valid_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            priv_m_o,
  input logic            tvec_init_o,
  input logic [1:0]      fault_level_o,
  input logic            halt_o
);
  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  a_r11_halt_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !redirect_valid_o);
  a_r3_redirect_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> trap_req_i);
  a_r3_aligned_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> redirect_pc_o[1:0] == 2'b00);
  a_r6_priv_after_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |=> priv_m_o);
  a_r7_init_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvec_init_o |=> tvec_init_o);
  a_r7_write_sets_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i |=> tvec_init_o);
  a_r7_uninit_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HALT_UNINIT && trap_req_i && !tvec_init_o) |=> halt_o);
  a_r9_nested_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ESCALATE && trap_req_i && fault_level_o != 2'd0) |=> halt_o);
  a_r10_triple_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_level_o == 2'd3 |-> halt_o);
endmodule

bind trap_entry_ctrl trap_entry_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .ESCALATE(ESCALATE), .HALT_UNINIT(HALT_UNINIT)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .csr_we_i        (csr_we_i),
  .trap_req_i      (trap_req_i),
  .redirect_valid_o(redirect_valid_o),
  .redirect_pc_o   (redirect_pc_o),
  .priv_m_o        (priv_m_o),
  .tvec_init_o     (tvec_init_o),
  .fault_level_o   (fault_level_o),
  .halt_o          (halt_o)
);

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
  localparam logic [31:0] HADDR = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic        a_we = 0, a_req = 0, a_irq = 0, a_ret = 0, a_mret = 0;
  logic [31:0] a_wd = 0;
  logic [4:0]  a_cause = 0;
  logic [31:0] a_rd, a_pc;
  logic        a_rv, a_pm, a_init, a_halt;
  logic [1:0]  a_lvl;

  logic        b_we = 0, b_req = 0, b_irq = 0, b_ret = 0, b_mret = 0;
  logic [31:0] b_wd = 0;
  logic [4:0]  b_cause = 0;
  logic [31:0] b_rd, b_pc;
  logic        b_rv, b_pm, b_init, b_halt;
  logic [1:0]  b_lvl;

  trap_entry_ctrl #(.HALT_ADDR(HADDR), .ESCALATE(1'b0), .HALT_UNINIT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(a_we), .csr_wdata_i(a_wd), .csr_rdata_o(a_rd),
    .trap_req_i(a_req), .trap_irq_i(a_irq), .trap_cause_i(a_cause),
    .handler_ret_i(a_ret), .mret_i(a_mret), .redirect_valid_o(a_rv), .redirect_pc_o(a_pc),
    .priv_m_o(a_pm), .tvec_init_o(a_init), .fault_level_o(a_lvl), .halt_o(a_halt));

  trap_entry_ctrl #(.HALT_ADDR(HADDR), .ESCALATE(1'b1), .HALT_UNINIT(1'b0)) dut_esc (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(b_we), .csr_wdata_i(b_wd), .csr_rdata_o(b_rd),
    .trap_req_i(b_req), .trap_irq_i(b_irq), .trap_cause_i(b_cause),
    .handler_ret_i(b_ret), .mret_i(b_mret), .redirect_valid_o(b_rv), .redirect_pc_o(b_pc),
    .priv_m_o(b_pm), .tvec_init_o(b_init), .fault_level_o(b_lvl), .halt_o(b_halt));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic a_write(input logic [31:0] v);
    @(negedge clk); a_we = 1; a_wd = v;
    @(negedge clk); a_we = 0;
    check("R2 read back", a_rd, v);
    check("R7 init set", {31'b0, a_init}, 32'd1);
  endtask

  task automatic a_trap(input logic irq, input logic [4:0] c, input logic ev,
                        input logic [31:0] epc, input string req);
    @(negedge clk); a_req = 1; a_irq = irq; a_cause = c;
    #1;
    check({req, " valid"}, {31'b0, a_rv}, {31'b0, ev});
    if (ev) check({req, " pc"}, a_pc, epc);
    @(negedge clk); a_req = 0;
  endtask

  task automatic a_retire();
    @(negedge clk); a_ret = 1;
    @(negedge clk); a_ret = 0;
    check("R8 retire clears level", {30'b0, a_lvl}, 32'd0);
  endtask

  task automatic b_trap(input logic [4:0] c, input logic ev, input logic [31:0] epc,
                        input string req);
    @(negedge clk); b_req = 1; b_irq = 0; b_cause = c;
    #1;
    check({req, " valid"}, {31'b0, b_rv}, {31'b0, ev});
    if (ev) check({req, " pc"}, b_pc, epc);
    @(negedge clk); b_req = 0;
  endtask

  task automatic t_reset_state();
    check("R1 tvec", a_rd, HADDR);
    check("R1 init", {31'b0, a_init}, 32'd0);
    check("R1 halt", {31'b0, a_halt}, 32'd0);
    check("R1 priv", {31'b0, a_pm}, 32'd1);
    check("R1 level", {30'b0, a_lvl}, 32'd0);
  endtask

  task automatic t_uninit_redirect();
    b_trap(5'd2, 1'b1, HADDR, "R7 uninit no-halt");
    check("R8 level 1", {30'b0, b_lvl}, 32'd1);
    check("R7 no halt", {31'b0, b_halt}, 32'd0);
    @(negedge clk); b_mret = 1;
    @(negedge clk); b_mret = 0;
    check("R6 mret priv", {31'b0, b_pm}, 32'd0);
    check("R8 mret level", {30'b0, b_lvl}, 32'd0);
  endtask

  task automatic t_direct();
    a_write(32'h8000_0000);
    a_trap(1'b0, 5'd3, 1'b1, 32'h8000_0000, "R3 direct exc");
    check("R8 level 1", {30'b0, a_lvl}, 32'd1);
    check("R6 priv set", {31'b0, a_pm}, 32'd1);
    a_retire();
    @(negedge clk); a_mret = 1;
    @(negedge clk); a_mret = 0;
    check("R6 mret priv", {31'b0, a_pm}, 32'd0);
    a_trap(1'b1, 5'd9, 1'b1, 32'h8000_0000, "R3 direct irq");
    check("R6 priv after trap", {31'b0, a_pm}, 32'd1);
    a_retire();
  endtask

  task automatic t_reserved();
    a_write(32'h8000_0003);
    a_trap(1'b1, 5'd7, 1'b1, 32'h8000_0000, "R5 mode3 irq");
    a_retire();
    a_write(32'h8000_0002);
    a_trap(1'b1, 5'd5, 1'b1, 32'h8000_0000, "R5 mode2 irq");
    a_retire();
  endtask

  task automatic t_vectored();
    a_write(32'h8000_0101);
    a_trap(1'b1, 5'd7, 1'b1, 32'h8000_011C, "R4 vec irq");
    a_retire();
    a_trap(1'b1, 5'd31, 1'b1, 32'h8000_017C, "R4 vec irq max");
    a_retire();
    a_trap(1'b0, 5'd2, 1'b1, 32'h8000_0100, "R4 vec exc");
    a_retire();
  endtask

  task automatic t_write_collide();
    @(negedge clk); a_we = 1; a_wd = 32'h4000_0000; a_req = 1; a_irq = 0; a_cause = 1;
    #1;
    check("R2 old value used", a_pc, 32'h8000_0100);
    @(negedge clk); a_we = 0; a_req = 0;
    check("R2 new value stored", a_rd, 32'h4000_0000);
    a_retire();
    a_trap(1'b0, 5'd1, 1'b1, 32'h4000_0000, "R2 next trap new");
  endtask

  task automatic t_nested();
    a_trap(1'b0, 5'd4, 1'b0, 32'h0, "R9 nested no redirect");
    check("R9 halt", {31'b0, a_halt}, 32'd1);
    check("R9 level double", {30'b0, a_lvl}, 32'd2);
    a_retire_halted();
    a_trap(1'b1, 5'd3, 1'b0, 32'h0, "R11 halted blocks");
    check("R11 halt sticky", {31'b0, a_halt}, 32'd1);
  endtask

  task automatic a_retire_halted();
    @(negedge clk); a_ret = 1;
    @(negedge clk); a_ret = 0;
    check("R11 halt after retire", {31'b0, a_halt}, 32'd1);
  endtask

  task automatic t_uninit_halt();
    a_trap(1'b0, 5'd2, 1'b0, 32'h0, "R7 uninit blocked");
    check("R7 uninit halt", {31'b0, a_halt}, 32'd1);
    check("R7 level unchanged", {30'b0, a_lvl}, 32'd0);
  endtask

  task automatic t_escalate();
    @(negedge clk); b_we = 1; b_wd = 32'h2000_0000;
    @(negedge clk); b_we = 0;
    b_trap(5'd1, 1'b1, 32'h2000_0000, "R10 first trap");
    check("R8 level 1", {30'b0, b_lvl}, 32'd1);
    b_trap(5'd2, 1'b1, 32'h2000_0000, "R10 double redirect");
    check("R10 level 2", {30'b0, b_lvl}, 32'd2);
    check("R10 no halt yet", {31'b0, b_halt}, 32'd0);
    b_trap(5'd3, 1'b0, 32'h0, "R10 triple blocked");
    check("R10 triple halt", {31'b0, b_halt}, 32'd1);
    check("R10 level 3", {30'b0, b_lvl}, 32'd3);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_uninit_redirect();
    t_direct();
    t_reserved();
    t_vectored();
    t_write_collide();
    t_nested();
    do_reset();
    t_reset_state();
    t_uninit_halt();
    t_escalate();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule